// File: doc/BRIEF.md
# Bitmap Screen Address Calculator

This unit computes byte addresses for a bitmap display memory whose rows are interleaved. A request takes one of two operations. The first turns a pixel coordinate into the address of the byte that holds that pixel. The coordinate is a row number and a column number. The second takes a byte address and returns the address of the byte one pixel row lower on the screen.

The display memory is not linear. The row number splits into three fields:

- The upper two bits pick one third of the screen.
- The middle three bits pick a character row inside that third.
- The lower three bits pick a pixel line inside the character row.

These fields land on scattered bits of the address. As a result, moving down one pixel row has three cases. The common case only increments the pixel-line field. The other two cases cross a character-row boundary or a third boundary.

The result is registered. It appears one clock after the request, together with a single-cycle valid strobe. The unit holds no flags and changes no condition state.

Top module: `scrn_addr_unit`

## Requirements
- R1: While reset is asserted, and after reset until the first request, `valid_o` is 0 and `addr_o` is 0x0000.
- R2: With `op_i`=0 (coordinate), the result is 0x4000 + (row[7:6] << 11) + (row[2:0] << 8) + (row[5:3] << 5) + (col >> 3).
- R3: Column bits 2..0 have no effect. The eight pixels in the same byte give the same address, and result bits 4..0 equal col[7:3].
- R4: With `op_i`=1 (step), if address bits 10..8 are not all ones, the result is the address plus 0x0100.
- R5: For step, if bits 10..8 are all ones and bits 7..5 are not all ones, the result is (address AND 0xF8FF) + 0x0020.
- R6: For step, if bits 10..8 and bits 7..5 are all ones, the result is (address AND 0xF81F) + 0x0800.
- R7: A request sampled at a clock edge gives `valid_o`=1 for exactly the following cycle, with the result on `addr_o` in that same cycle.
- R8: Without a request, `addr_o` keeps its last value and `valid_o` is 0, whatever the other inputs do.
- R9: For every row y from 0 to 190 and every byte column, stepping from the address of (y, col) gives the address of (y+1, col).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe, one operation per cycle |
| op_i | input | 1 | 0 = coordinate to address, 1 = step one row down |
| row_i | input | 8 | Pixel row (coordinate operation) |
| col_i | input | 8 | Pixel column (coordinate operation) |
| addr_i | input | 16 | Current byte address (step operation) |
| addr_o | output | 16 | Registered result address |
| valid_o | output | 1 | Pulses for one cycle when `addr_o` holds a new result |

## Verification
The coordinate operation is tried with several kinds of rows:

- The corner rows 0 and 255 confirm the extremes.
- Single-field rows isolate each scattered bit field, so a swapped or misplaced field shows up alone.
- A row with mixed bits catches fields that add into each other.

The eight columns inside one byte show that the low column bits are dropped. Step inputs are chosen on both sides of each of the three case boundaries, so a wrong case selection or a wrong mask can be told apart. An exhaustive sweep of rows 0 to 190 over all byte columns compares each step result against the coordinate address of the next row. This ties the two operations together at every character-row and third crossing.

// File: rtl/scrn_pkg.sv
package scrn_pkg;

   typedef enum logic {
      OP_COORD = 1'b0,
      OP_STEP  = 1'b1
   } scrn_op_e;

   // Address bit positions of the row fields in the interleaved layout
   localparam int LINE_LSB  = 8;   // pixel line inside a character row
   localparam int CROW_LSB  = 5;   // character row inside a third
   localparam int THIRD_LSB = 11;  // screen third
   localparam int FIELD_W   = 3;   // width of line and character-row fields
   localparam int THIRD_W   = 2;
   localparam int PIX_LOG2  = 3;   // eight pixels per byte

endpackage

// File: rtl/scrn_coord_map.sv
module scrn_coord_map
   import scrn_pkg::*;
#(
   parameter int              ADDR_W    = 16,
   parameter int              COORD_W   = 8,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h4000
) (
   input  logic [COORD_W-1:0] row_i,
   input  logic [COORD_W-1:0] col_i,
   output logic [ADDR_W-1:0]  addr_o
);
   localparam int BYTE_COL_W = COORD_W - PIX_LOG2;

   if (COORD_W != FIELD_W * 2 + THIRD_W) begin : g_bad_coord
      $error("scrn_coord_map: COORD_W must equal the sum of the row fields");
   end
   if (ADDR_W < THIRD_LSB + THIRD_W) begin : g_bad_addr
      $error("scrn_coord_map: ADDR_W too narrow for the layout");
   end

   logic [COORD_W-1:0]    byte_col_full;
   logic [BYTE_COL_W-1:0] byte_col;
   logic [ADDR_W-1:0]     offset;

   always_comb begin
      byte_col_full = col_i >> PIX_LOG2;
      byte_col      = byte_col_full[BYTE_COL_W-1:0];
      offset        = '0;
      offset[BYTE_COL_W-1:0]                 = byte_col;
      offset[CROW_LSB +: FIELD_W]            = row_i[FIELD_W +: FIELD_W];
      offset[LINE_LSB +: FIELD_W]            = row_i[0 +: FIELD_W];
      offset[THIRD_LSB +: THIRD_W]           = row_i[2*FIELD_W +: THIRD_W];
      addr_o = BASE_ADDR + offset;
   end
endmodule

// File: rtl/scrn_row_step.sv
module scrn_row_step
   import scrn_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  logic [ADDR_W-1:0] addr_i,
   output logic [ADDR_W-1:0] addr_o
);
   localparam logic [ADDR_W-1:0] LINE_ONE  = ADDR_W'(1) << LINE_LSB;
   localparam logic [ADDR_W-1:0] CROW_ONE  = ADDR_W'(1) << CROW_LSB;
   localparam logic [ADDR_W-1:0] THIRD_ONE = ADDR_W'(1) << THIRD_LSB;
   localparam logic [ADDR_W-1:0] LINE_MASK = ADDR_W'((1 << FIELD_W) - 1) << LINE_LSB;
   localparam logic [ADDR_W-1:0] CROW_MASK = ADDR_W'((1 << FIELD_W) - 1) << CROW_LSB;

   logic line_full, crow_full;
   logic [ADDR_W-1:0] nxt_line, nxt_crow, nxt_third;

   always_comb begin
      line_full = &addr_i[LINE_LSB +: FIELD_W];
      crow_full = &addr_i[CROW_LSB +: FIELD_W];
      nxt_line  = addr_i + LINE_ONE;
      nxt_crow  = (addr_i & ~LINE_MASK) + CROW_ONE;
      nxt_third = (addr_i & ~(LINE_MASK | CROW_MASK)) + THIRD_ONE;
      if (!line_full)      addr_o = nxt_line;
      else if (!crow_full) addr_o = nxt_crow;
      else                 addr_o = nxt_third;
   end
endmodule

// File: rtl/scrn_out_reg.sv
module scrn_out_reg #(
   parameter int ADDR_W     = 16,
   parameter bit RESET_DATA = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] d_i,
   output logic [ADDR_W-1:0] q_o,
   output logic              valid_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) valid_o <= 1'b0;
      else        valid_o <= load_i;
   end

   if (RESET_DATA) begin : g_rst_data
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      q_o <= '0;
         else if (load_i) q_o <= d_i;
      end
   end else begin : g_norst_data
      always_ff @(posedge clk) begin
         if (load_i) q_o <= d_i;
      end
   end
endmodule

// File: rtl/scrn_addr_unit.sv
module scrn_addr_unit
   import scrn_pkg::*;
#(
   parameter int                ADDR_W    = 16,
   parameter int                COORD_W   = 8,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h4000,
   parameter bit                RESET_DATA = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_i,
   input  logic               op_i,
   input  logic [COORD_W-1:0] row_i,
   input  logic [COORD_W-1:0] col_i,
   input  logic [ADDR_W-1:0]  addr_i,
   output logic [ADDR_W-1:0]  addr_o,
   output logic               valid_o
);
   scrn_op_e          op;
   logic [ADDR_W-1:0] coord_addr, step_addr, result;

   assign op = scrn_op_e'(op_i);

   scrn_coord_map #(.ADDR_W(ADDR_W), .COORD_W(COORD_W), .BASE_ADDR(BASE_ADDR)) u_map (
      .row_i (row_i),
      .col_i (col_i),
      .addr_o(coord_addr)
   );

   scrn_row_step #(.ADDR_W(ADDR_W)) u_step (
      .addr_i(addr_i),
      .addr_o(step_addr)
   );

   always_comb result = (op == OP_STEP) ? step_addr : coord_addr;

   scrn_out_reg #(.ADDR_W(ADDR_W), .RESET_DATA(RESET_DATA)) u_reg (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (req_i),
      .d_i    (result),
      .q_o    (addr_o),
      .valid_o(valid_o)
   );

   AST_VALID_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      req_i |=> valid_o); // R7
   AST_VALID_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
      !req_i |=> !valid_o); // R7
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !req_i |=> $stable(addr_o)); // R8
   AST_COL_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && !op_i) |=> addr_o[COORD_W-PIX_LOG2-1:0] == $past(col_i[COORD_W-1:PIX_LOG2])); // R3
   AST_STEP_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && op_i && !(&addr_i[LINE_LSB +: FIELD_W])) |=>
      (addr_o[LINE_LSB-1:0] == $past(addr_i[LINE_LSB-1:0]) &&
       addr_o[LINE_LSB +: FIELD_W] == $past(addr_i[LINE_LSB +: FIELD_W]) + 3'd1)); // R4
   AST_STEP_CROW: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && op_i && (&addr_i[LINE_LSB +: FIELD_W]) && !(&addr_i[CROW_LSB +: FIELD_W])) |=>
      (addr_o[LINE_LSB +: FIELD_W] == 3'd0 &&
       addr_o[CROW_LSB-1:0] == $past(addr_i[CROW_LSB-1:0]))); // R5
   AST_STEP_THIRD: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && op_i && (&addr_i[LINE_LSB +: FIELD_W]) && (&addr_i[CROW_LSB +: FIELD_W])) |=>
      (addr_o[LINE_LSB +: FIELD_W] == 3'd0 && addr_o[CROW_LSB +: FIELD_W] == 3'd0)); // R6
endmodule

// File: tb/scrn_addr_unit_test.sv
module scrn_addr_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_i = 1'b0;
   logic        op_i = 1'b0;
   logic [7:0]  row_i = '0;
   logic [7:0]  col_i = '0;
   logic [15:0] addr_i = '0;
   logic [15:0] addr_o;
   logic        valid_o;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   scrn_addr_unit uut (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .op_i(op_i),
      .row_i(row_i), .col_i(col_i), .addr_i(addr_i),
      .addr_o(addr_o), .valid_o(valid_o)
   );

   // {op, row, col, addr_in, expected, requirement tag}
   typedef struct packed {
      logic        op;
      logic [7:0]  row;
      logic [7:0]  col;
      logic [15:0] ain;
      logic [15:0] exp;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 8'h00, 8'h00, 16'h0000, 16'h4000, 8'd2},
      '{1'b0, 8'hFF, 8'hFF, 16'h0000, 16'h5FFF, 8'd2},
      '{1'b0, 8'h01, 8'h08, 16'h0000, 16'h4101, 8'd2},
      '{1'b0, 8'h08, 8'h10, 16'h0000, 16'h4022, 8'd2},
      '{1'b0, 8'h40, 8'h07, 16'h0000, 16'h4800, 8'd3},
      '{1'b0, 8'hA5, 8'hC9, 16'h0000, 16'h5599, 8'd2},
      '{1'b1, 8'h00, 8'h00, 16'h4000, 16'h4100, 8'd4},
      '{1'b1, 8'h00, 8'h00, 16'h4600, 16'h4700, 8'd4},
      '{1'b1, 8'h00, 8'h00, 16'h4705, 16'h4025, 8'd5},
      '{1'b1, 8'h00, 8'h00, 16'h47C3, 16'h40E3, 8'd5},
      '{1'b1, 8'h00, 8'h00, 16'h47E4, 16'h4804, 8'd6},
      '{1'b1, 8'h00, 8'h00, 16'h4FFF, 16'h501F, 8'd6},
      '{1'b1, 8'h00, 8'h00, 16'h57FF, 16'h581F, 8'd6}
   };

   function automatic logic [15:0] model_addr(input int y, input int x);
      int third, crow, line;
      third = y / 64;
      crow  = (y / 8) % 8;
      line  = y % 8;
      return 16'(16'h4000 + third * 2048 + line * 256 + crow * 32 + x / 8);
   endfunction

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic issue(input logic op, input logic [7:0] r, input logic [7:0] c,
                        input logic [15:0] a);
      @(negedge clk);
      req_i = 1'b1; op_i = op; row_i = r; col_i = c; addr_i = a;
      @(negedge clk);
      req_i = 1'b0;
   endtask

   task automatic finish_run;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [15:0] held;
      // R1 reset state
      repeat (3) @(negedge clk);
      check("R1 addr in reset", addr_o, 16'h0000);
      check("R1 valid in reset", {15'd0, valid_o}, 16'h0001 & 16'h0000);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 addr after reset", addr_o, 16'h0000);

      // table walk
      for (int i = 0; i < NV; i++) begin
         issue(VECS[i].op, VECS[i].row, VECS[i].col, VECS[i].ain);
         check($sformatf("R%0d vector %0d", VECS[i].req, i), addr_o, VECS[i].exp);
         check("R7 valid with result", {15'd0, valid_o}, 16'h0001);
      end

      // R7 single pulse, R8 hold while idle with moving inputs
      issue(1'b0, 8'h3C, 8'h5A, 16'h0000);
      held = addr_o;
      check("R2 mixed row", held, model_addr(8'h3C, 8'h5A));
      for (int k = 0; k < 3; k++) begin
         row_i = 8'(k * 37 + 11); col_i = 8'(k * 91); addr_i = 16'(k * 4099); op_i = k[0];
         @(negedge clk);
         check("R7 valid low when idle", {15'd0, valid_o}, 16'h0000);
         check("R8 addr held when idle", addr_o, held);
      end

      // R3 all pixels of one byte
      for (int p = 0; p < 8; p++) begin
         issue(1'b0, 8'h92, 8'(8'hB0 + p), 16'h0000);
         check("R3 pixel within byte", addr_o, model_addr(8'h92, 8'hB0));
      end

      // R9 sweep: coordinate and step agree row by row
      for (int y = 0; y <= 190; y++) begin
         for (int x = 0; x < 256; x += 8) begin
            issue(1'b0, 8'(y), 8'(x), 16'h0000);
            check("R2 sweep coordinate", addr_o, model_addr(y, x));
            issue(1'b1, 8'h00, 8'h00, model_addr(y, x));
            check("R9 step equals next row", addr_o, model_addr(y + 1, x));
         end
      end

      // R1 reset again mid-run clears output
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 addr cleared by reset", addr_o, 16'h0000);
      check("R1 valid cleared by reset", {15'd0, valid_o}, 16'h0000);
      finish_run();
   end
endmodule